// File: doc/BRIEF.md
# Priority Nested Interrupt Controller

This block collects a vector of interrupt request lines and decides which one should interrupt the processor next. Each source has three settings held in the block: an enable bit, a priority level and a pending flag. One global grouping setting applies to all sources. A rising edge on a request line marks that source pending. Among the sources that are pending, enabled and not already being serviced, the one with the most urgent priority is offered to the core through a take request. A lower level number is more urgent. When two candidates have the same level, the lower source number wins.

A candidate may interrupt the running handler only when it is more urgent in the preemption part of its level. The grouping value decides how many of the low level bits form a sub-priority. The sub-priority ranks sources that are waiting together, but it never allows one handler to interrupt another.

When the core accepts an offer, the source moves from pending to active. The source's number plus 16 then becomes the reported exception number, and a small nesting stack records the interrupted context. An exception-return strobe removes the newest entry from the stack and restores the previous exception number. Exception number 0 means no handler is running.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A priority write keeps only the top PRIO_BITS bits of the data byte (bits [7:5] by default) as the level. Reading the priority back (select 1) returns the level in those bits with every lower bit zero.
- R2: Select 0 writes the enable bit from data bit 0 and reads it back in bit 0. Select 2 writes the grouping value from data bits [1:0] and reads it back in the same bits. Select 3 reads as zero.
- R3: A rising edge on a request line sets that source's pending flag, and the flag stays set until the source is taken. A pending source that is disabled is never offered.
- R4: The offered source is the one with the numerically lowest level among the sources that are pending, enabled and not active. On a tie the lowest source number wins. take_exc_o reports the source index plus 16, and reads 0 when nothing is offered.
- R5: With grouping value g, the low g bits of a level are sub-priority and the rest is the preemption group. While a handler is active, a candidate is offered only when its preemption group is strictly lower than that of the active handler.
- R6: An accepted take clears the source's pending flag and sets its active flag. From the next cycle act_exc_o shows the source index plus 16. It reads 0 when no handler is active.
- R7: An exception-return strobe ends the newest active handler and restores the previous exception number, or 0 if none remains. A take asserted in the same cycle is ignored and the candidate stays pending.
- R8: A request that rises while the same source is active sets it pending again. The source is offered only after its handler returns.
- R9: Up to NEST_DEPTH handlers can nest, and they return in reverse order. While the stack is full, no candidate is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all state and settings |
| irq_req_i | input | NUM_SRC | Request lines; a rising edge marks the source pending |
| cfg_we_i | input | 1 | Setting write strobe |
| cfg_sel_i | input | 2 | Setting select: 0 enable, 1 priority, 2 grouping, 3 none |
| cfg_idx_i | input | IDX_W | Source index for enable and priority access |
| cfg_wdata_i | input | 8 | Setting write data |
| cfg_rdata_o | output | 8 | Setting read data for the current select and index |
| take_req_o | output | 1 | A candidate may preempt now |
| take_exc_o | output | 9 | Exception number of the candidate (0 if none) |
| take_ack_i | input | 1 | Core accepts the offered candidate |
| eret_i | input | 1 | Exception-return strobe |
| act_exc_o | output | 9 | Exception number of the running handler (0 = thread) |

## Verification
The selection logic is swept across all 256 enable masks while every source is pending. The priority pattern contains tied levels, so the sweep shows both that the most urgent level wins and that the lower index wins a tie.

Preemption is tested for every grouping value and every pair of active and candidate levels. This separates a strict group compare from a compare on the full level, from a non-strict compare and from one that ignores grouping. It also confirms that a refused candidate is served after the handler returns.

Directed sequences cover several cases:
- a re-raised request on an active source;
- a return and a take in the same cycle;
- a nesting chain that fills the stack, suppresses a candidate while full, and then unwinds in order.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int EXC_W    = 9;
   localparam int EXC_BASE = 16;

   typedef enum logic [1:0] {
      SEL_EN   = 2'd0,
      SEL_PRIO = 2'd1,
      SEL_GRP  = 2'd2,
      SEL_NONE = 2'd3
   } cfg_sel_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_pkg::*;
#(
   parameter int NUM_SRC   = 138,
   parameter int PRIO_BITS = 3,
   parameter int IDX_W     = 8,
   parameter int GRP_W     = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we_i,
   input  logic [1:0]                        sel_i,
   input  logic [IDX_W-1:0]                  idx_i,
   input  logic [7:0]                        wdata_i,
   output logic [NUM_SRC-1:0]                en_o,
   output logic [NUM_SRC-1:0][PRIO_BITS-1:0] lvl_o,
   output logic [GRP_W-1:0]                  grp_o,
   output logic [7:0]                        rdata_o
);
   localparam int DROP = 8 - PRIO_BITS;

   logic [PRIO_BITS-1:0] lvl_wr;
   logic [GRP_W-1:0]     grp_wr;

   assign lvl_wr = PRIO_BITS'(wdata_i >> DROP);
   assign grp_wr = wdata_i[GRP_W-1:0];

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_o[i]  <= 1'b0;
            lvl_o[i] <= '0;
         end else if (we_i && idx_i == IDX_W'(i)) begin
            if (sel_i == SEL_EN)   en_o[i]  <= wdata_i[0];
            if (sel_i == SEL_PRIO) lvl_o[i] <= lvl_wr;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_o <= '0;
      end else if (we_i && sel_i == SEL_GRP) begin
         if (grp_wr > GRP_W'(PRIO_BITS)) grp_o <= GRP_W'(PRIO_BITS);
         else                            grp_o <= grp_wr;
      end
   end

   always_comb begin
      rdata_o = '0;
      if (sel_i == SEL_GRP) rdata_o = 8'(grp_o);
      for (int i = 0; i < NUM_SRC; i++) begin
         if (idx_i == IDX_W'(i)) begin
            if (sel_i == SEL_EN)   rdata_o = {7'b0, en_o[i]};
            if (sel_i == SEL_PRIO) rdata_o = 8'(lvl_o[i]) << DROP;
         end
      end
   end

   // R1
   lvl_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == SEL_PRIO) |-> ((rdata_o & 8'((9'd1 << DROP) - 9'd1)) == 8'd0));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int NUM_SRC   = 138,
   parameter int PRIO_BITS = 3,
   parameter int IDX_W     = 8
) (
   input  logic [NUM_SRC-1:0]                elig_i,
   input  logic [NUM_SRC-1:0][PRIO_BITS-1:0] lvl_i,
   output logic                              found_o,
   output logic [IDX_W-1:0]                  win_idx_o,
   output logic [PRIO_BITS-1:0]              win_lvl_o
);
   always_comb begin
      found_o   = 1'b0;
      win_idx_o = '0;
      win_lvl_o = '1;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (elig_i[i] && (!found_o || lvl_i[i] < win_lvl_o)) begin
            found_o   = 1'b1;
            win_idx_o = IDX_W'(i);
            win_lvl_o = lvl_i[i];
         end
      end
   end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
   parameter int DEPTH     = 8,
   parameter int IDX_W     = 8,
   parameter int PRIO_BITS = 3,
   parameter int CNT_W     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 push_i,
   input  logic                 pop_i,
   input  logic [IDX_W-1:0]     push_idx_i,
   input  logic [PRIO_BITS-1:0] push_lvl_i,
   output logic [CNT_W-1:0]     depth_o,
   output logic                 full_o,
   output logic                 top_valid_o,
   output logic [IDX_W-1:0]     top_idx_o,
   output logic [PRIO_BITS-1:0] top_lvl_o
);
   logic [IDX_W-1:0]     idx_q [DEPTH];
   logic [PRIO_BITS-1:0] lvl_q [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            idx_q[k] <= '0;
            lvl_q[k] <= '0;
         end else if (push_i && depth_o == CNT_W'(k)) begin
            idx_q[k] <= push_idx_i;
            lvl_q[k] <= push_lvl_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            depth_o <= '0;
      else if (push_i && !full_o)            depth_o <= depth_o + 1'b1;
      else if (pop_i && depth_o != '0)       depth_o <= depth_o - 1'b1;
   end

   assign full_o      = (depth_o == CNT_W'(DEPTH));
   assign top_valid_o = (depth_o != '0);

   always_comb begin
      top_idx_o = '0;
      top_lvl_o = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (depth_o == CNT_W'(k + 1)) begin
            top_idx_o = idx_q[k];
            top_lvl_o = lvl_q[k];
         end
      end
   end

   // R9
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      depth_o <= CNT_W'(DEPTH));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_pkg::*;
#(
   parameter  int NUM_SRC    = 138,
   parameter  int PRIO_BITS  = 3,
   parameter  int NEST_DEPTH = 8,
   localparam int IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_req_i,
   input  logic               cfg_we_i,
   input  logic [1:0]         cfg_sel_i,
   input  logic [IDX_W-1:0]   cfg_idx_i,
   input  logic [7:0]         cfg_wdata_i,
   output logic [7:0]         cfg_rdata_o,
   output logic               take_req_o,
   output logic [EXC_W-1:0]   take_exc_o,
   input  logic               take_ack_i,
   input  logic               eret_i,
   output logic [EXC_W-1:0]   act_exc_o
);
   localparam int GRP_W = $clog2(PRIO_BITS + 1);
   localparam int CNT_W = $clog2(NEST_DEPTH + 1);

   if (NUM_SRC < 1 || NUM_SRC > (1 << EXC_W) - EXC_BASE) begin : g_bad_src
      $error("NUM_SRC out of range for the exception number field");
   end
   if (PRIO_BITS < 1 || PRIO_BITS > 8) begin : g_bad_prio
      $error("PRIO_BITS must be 1 to 8");
   end
   if (NEST_DEPTH < 1) begin : g_bad_depth
      $error("NEST_DEPTH must be at least 1");
   end

   logic [NUM_SRC-1:0]                req_q, pend_q, act_q;
   logic [NUM_SRC-1:0]                en, rise, take_mask, pop_mask;
   logic [NUM_SRC-1:0][PRIO_BITS-1:0] lvl;
   logic [GRP_W-1:0]                  grp;
   logic [PRIO_BITS-1:0]              grp_mask, win_lvl, top_lvl;
   logic [IDX_W-1:0]                  win_idx, top_idx;
   logic [CNT_W-1:0]                  depth;
   logic                              found, full, top_valid, do_take, do_pop;

   irq_cfg_regs #(.NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS), .IDX_W(IDX_W), .GRP_W(GRP_W)) cfg_i (
      .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .sel_i(cfg_sel_i), .idx_i(cfg_idx_i),
      .wdata_i(cfg_wdata_i), .en_o(en), .lvl_o(lvl), .grp_o(grp), .rdata_o(cfg_rdata_o));

   irq_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS), .IDX_W(IDX_W)) arb_i (
      .elig_i(pend_q & en & ~act_q), .lvl_i(lvl),
      .found_o(found), .win_idx_o(win_idx), .win_lvl_o(win_lvl));

   irq_nest_stack #(.DEPTH(NEST_DEPTH), .IDX_W(IDX_W), .PRIO_BITS(PRIO_BITS), .CNT_W(CNT_W)) stk_i (
      .clk(clk), .rst_n(rst_n), .push_i(do_take), .pop_i(do_pop),
      .push_idx_i(win_idx), .push_lvl_i(win_lvl), .depth_o(depth), .full_o(full),
      .top_valid_o(top_valid), .top_idx_o(top_idx), .top_lvl_o(top_lvl));

   assign grp_mask   = {PRIO_BITS{1'b1}} << grp;
   assign take_req_o = found && !full &&
                       (!top_valid || (win_lvl & grp_mask) < (top_lvl & grp_mask));
   assign take_exc_o = take_req_o ? EXC_W'(win_idx) + EXC_W'(EXC_BASE) : '0;
   assign act_exc_o  = top_valid ? EXC_W'(top_idx) + EXC_W'(EXC_BASE) : '0;

   assign do_pop    = eret_i && top_valid;
   assign do_take   = take_ack_i && take_req_o && !eret_i;
   assign rise      = irq_req_i & ~req_q;
   assign take_mask = do_take ? (NUM_SRC'(1) << win_idx) : '0;
   assign pop_mask  = do_pop ? (NUM_SRC'(1) << top_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= '0;
         pend_q <= '0;
         act_q  <= '0;
      end else begin
         req_q  <= irq_req_i;
         pend_q <= (pend_q & ~take_mask) | rise;
         act_q  <= (act_q | take_mask) & ~pop_mask;
      end
   end

   // R6
   act_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(act_q) == int'(depth));

   // R6
   take_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_ack_i && take_req_o && !eret_i) |=> (act_exc_o == $past(take_exc_o)));

   // R7
   eret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eret_i && act_exc_o != '0) |=> ($countones(act_q) + 1 == $past($countones(act_q))));

   // R8
   act_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_req_o |-> !act_q[win_idx]);

   // R3
   cand_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_req_o |-> (pend_q[win_idx] && en[win_idx]));
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
   localparam int NS = 8;
   localparam int ND = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] irq_req = '0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_sel = 2'd0;
   logic [2:0]    cfg_idx = '0;
   logic [7:0]    cfg_wdata = '0;
   logic [7:0]    cfg_rdata;
   logic          take_req;
   logic [8:0]    take_exc;
   logic          take_ack = 1'b0;
   logic          eret = 1'b0;
   logic [8:0]    act_exc;

   int nchk = 0;
   int nfail = 0;

   always #2 clk = ~clk;

   irq_prio_ctrl #(.NUM_SRC(NS), .PRIO_BITS(3), .NEST_DEPTH(ND)) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
      .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
      .take_req_o(take_req), .take_exc_o(take_exc), .take_ack_i(take_ack),
      .eret_i(eret), .act_exc_o(act_exc));

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; irq_req = '0; cfg_we = 1'b0; take_ack = 1'b0; eret = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input int sel, input int idx, input int data);
      cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_idx = 3'(idx); cfg_wdata = 8'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input int sel, input int idx, output int data);
      cfg_sel = 2'(sel); cfg_idx = 3'(idx);
      #1 data = int'(cfg_rdata);
      @(negedge clk);
   endtask

   task automatic pulse(input logic [NS-1:0] m);
      irq_req = m;
      @(negedge clk);
      irq_req = '0;
   endtask

   task automatic take();
      take_ack = 1'b1;
      @(negedge clk);
      take_ack = 1'b0;
   endtask

   task automatic ret();
      eret = 1'b1;
      @(negedge clk);
      eret = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      int v;
      int plv [NS];
      plv = '{5, 2, 5, 2, 7, 3, 3, 6};
      do_reset();

      // reset state
      chk("R6 reset act", int'(act_exc), 0);
      chk("R4 reset take_req", int'(take_req), 0);
      rd(1, 2, v); chk("R1 reset prio", v, 0);
      rd(0, 2, v); chk("R2 reset enable", v, 0);

      // R1 priority byte sweep
      for (int d = 0; d < 256; d++) begin
         wr(1, 3, d);
         rd(1, 3, v);
         chk("R1 prio readback", v, d & 8'hE0);
      end

      // R2 enable and grouping readback
      wr(0, 5, 8'hFF); rd(0, 5, v); chk("R2 enable set", v, 1);
      wr(0, 5, 8'hFE); rd(0, 5, v); chk("R2 enable clear", v, 0);
      for (int g = 0; g < 8; g++) begin
         wr(2, 0, g); rd(2, 0, v); chk("R2 grouping", v, g & 3);
      end
      rd(3, 0, v); chk("R2 select none", v, 0);

      // R3/R4 arbitration over all enable masks
      do_reset();
      for (int i = 0; i < NS; i++) wr(1, i, plv[i] << 5);
      pulse('1);
      chk("R3 disabled not offered", int'(take_req), 0);
      for (int m = 0; m < 256; m++) begin
         int best, bl;
         for (int i = 0; i < NS; i++) wr(0, i, (m >> i) & 1);
         best = -1; bl = 8;
         for (int i = 0; i < NS; i++)
            if (((m >> i) & 1) != 0 && plv[i] < bl) begin best = i; bl = plv[i]; end
         chk("R4 offer valid", int'(take_req), (best >= 0) ? 1 : 0);
         chk("R4 offer number", int'(take_exc), (best >= 0) ? best + 16 : 0);
      end

      // R5 preemption sweep over grouping and level pairs
      for (int g = 0; g < 4; g++)
         for (int x = 0; x < 8; x++)
            for (int y = 0; y < 8; y++) begin
               int exp_pre;
               do_reset();
               wr(2, 0, g); wr(1, 0, x << 5); wr(1, 1, y << 5);
               wr(0, 0, 1); wr(0, 1, 1);
               pulse(8'h01);
               take();
               chk("R6 first taken", int'(act_exc), 16);
               pulse(8'h02);
               exp_pre = ((y >> g) < (x >> g)) ? 1 : 0;
               chk("R5 preempt decision", int'(take_req), exp_pre);
               if (exp_pre != 0) begin
                  take();
                  chk("R6 nested taken", int'(act_exc), 17);
                  ret();
                  chk("R7 restore outer", int'(act_exc), 16);
                  ret();
                  chk("R7 back to thread", int'(act_exc), 0);
               end else begin
                  ret();
                  chk("R7 back to thread", int'(act_exc), 0);
                  chk("R5 deferred offer", int'(take_exc), 17);
               end
            end

      // R8 re-request while active
      do_reset();
      wr(0, 0, 1);
      pulse(8'h01); take();
      chk("R8 active", int'(act_exc), 16);
      pulse(8'h01);
      chk("R8 not offered while active", int'(take_req), 0);
      ret();
      chk("R8 offered after return", int'(take_exc), 16);

      // R7 return and take in the same cycle
      do_reset();
      wr(1, 0, 2 << 5); wr(0, 0, 1); wr(0, 1, 1);
      pulse(8'h01); take();
      pulse(8'h02);
      chk("R7 preempt ready", int'(take_exc), 17);
      take_ack = 1'b1; eret = 1'b1;
      @(negedge clk);
      take_ack = 1'b0; eret = 1'b0;
      chk("R7 take ignored on return", int'(act_exc), 0);
      chk("R7 candidate kept", int'(take_exc), 17);
      take();
      chk("R7 later take", int'(act_exc), 17);

      // R9 nesting chain, full stack, unwind
      do_reset();
      for (int i = 0; i < 5; i++) begin wr(1, i, (7 - i) << 5); wr(0, i, 1); end
      for (int i = 0; i < ND; i++) begin
         pulse(8'(1 << i));
         chk("R9 chain offer", int'(take_exc), 16 + i);
         take();
         chk("R9 chain active", int'(act_exc), 16 + i);
      end
      pulse(8'h10);
      chk("R9 full suppresses", int'(take_req), 0);
      ret();
      chk("R9 unwind 1", int'(act_exc), 18);
      chk("R9 offer after room", int'(take_exc), 20);
      ret(); chk("R9 unwind 2", int'(act_exc), 17);
      ret(); chk("R9 unwind 3", int'(act_exc), 16);
      ret(); chk("R9 unwind 4", int'(act_exc), 0);
      chk("R9 pending kept", int'(take_exc), 20);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule